// File: doc/BRIEF.md
# Down-Counting Event Timer

A single-channel event timer on a 32-bit register port. It has two registers: a control word at offset 0x40 and a timeout value at offset 0x44. Software sets the enable bit in the control word and then writes a tick count to the value register. That write is the start trigger. The counter then steps down by one each clock. When it reaches zero it stops and raises a pending flag. The interrupt line carries the pending flag gated by the interrupt-enable bit. Software acknowledges the event by writing the clear bit together with the enable bit.

While the timer is disabled, writes to the value register are ignored, and so are changes to interrupt enable and clear. Dropping the enable bit in the middle of a countdown freezes the counter, and enabling it again resumes the count from the frozen value. The block accepts at most one register write per clock. Reads are combinational from the address.

The core is a five-state machine:
- OFF: disabled, idle.
- IDLE: enabled, no countdown has been started.
- RUN: counting down.
- HOLD: disabled in the middle of a countdown, counter frozen.
- DONE: enabled, the count has reached zero.

The transitions are:
- OFF→IDLE: a control write with enable set.
- IDLE→OFF: a control write with enable clear.
- IDLE→RUN: a value write.
- RUN→RUN: a value write reloads the counter.
- RUN→HOLD: a control write with enable clear.
- RUN→DONE: the count is 1 or 0 at a clock edge with no write.
- HOLD→RUN: a control write with enable set.
- DONE→RUN: a value write.
- DONE→OFF: a control write with enable clear.

Top module: `evt_countdown_timer`

## Requirements
- R1: After reset the control readback is 0, the value readback is 0, no event is pending and irq is low.
- R2: The block fully decodes all 8 address bits. Control is at 0x40 and value at 0x44. Other addresses read as 0, and writes to them change nothing.
- R3: A write to 0x44 while enabled loads the count from wdata (any 32-bit value, 0xFFFFFFFF included) on that clock edge and starts the countdown. A write to 0x44 while disabled is ignored.
- R4: During a countdown the count drops by one per clock, and reading 0x44 returns the remaining count. With a loaded value V, the count reaches 0 and the pending flag sets max(V,1) clock edges after the write edge. The count then stays at 0.
- R5: irq equals pending AND interrupt-enable.
- R6: A control write with bit 0 = 1 sets enable, sets interrupt-enable to wdata bit 1, and clears pending when bit 4 = 1. A control write with bit 0 = 0 clears both enable and interrupt-enable, ignores bits 1 and 4, and keeps pending as it was.
- R7: Clearing enable during a countdown freezes the count, and value writes have no effect while frozen. Setting enable again resumes counting from the frozen value.
- R8: Control readback is bit 0 = enable and bit 1 = interrupt-enable. All other bits read 0, including the write-only clear bit 4.
- R9: A value write during a countdown reloads the count. The countdown restarts from the new value.
- R10: When expiry and a clear write fall on the same clock edge, expiry wins and pending is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The countdown is tried with every start value from 0 to 12. The count and irq are checked after each edge, which separates a count that stops one edge early or late from one that lands on time, and separates the zero-value case from the value-one case. All 32 combinations of the low five control bits are applied to a timer with an event pending. The effect of each is read back through the control register and the irq line, which tells apart the gating of interrupt-enable and clear by enable and the keeping of pending across a disable. Further directed sequences cover:
- freezing and resuming a countdown;
- a reload during a countdown;
- a value write while disabled;
- a clear that lands on the expiry edge;
- the full-scale value;
- aliased and unmapped addresses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_DONE
    } tmr_state_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_IE_BIT  = 1;
    localparam int CTL_CLR_BIT = 4;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              irq_en,
    input  logic [DATA_W-1:0] count,
    output logic              ctrl_we,
    output logic              val_we,
    output logic [DATA_W-1:0] rdata
);
    import tmr_pkg::*;

    logic hit_ctrl, hit_val;

    assign hit_ctrl = (addr == CTRL_OFS);
    assign hit_val  = (addr == VAL_OFS);
    assign ctrl_we  = wr_en && hit_ctrl;
    assign val_we   = wr_en && hit_val;

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CTL_EN_BIT] = en;
            rdata[CTL_IE_BIT] = irq_en;
        end else if (hit_val) begin
            rdata = count;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              val_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic              irq_en,
    output logic [DATA_W-1:0] count,
    output logic              irq
);
    import tmr_pkg::*;

    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_q;
    logic              ie_q, pending_q;
    logic              w_en, w_ie, w_clr;
    logic              ctl_on, ctl_off, expire, decr;

    assign w_en    = wdata[CTL_EN_BIT];
    assign w_ie    = wdata[CTL_IE_BIT];
    assign w_clr   = wdata[CTL_CLR_BIT];
    assign ctl_on  = ctrl_we && w_en;
    assign ctl_off = ctrl_we && !w_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (ctl_on) state_d = ST_IDLE;
            ST_IDLE: begin
                if (ctl_off)     state_d = ST_OFF;
                else if (val_we) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_off)                  state_d = ST_HOLD;
                else if (val_we)              state_d = ST_RUN;
                else if (count_q <= DATA_W'(1)) state_d = ST_DONE;
            end
            ST_HOLD: if (ctl_on) state_d = ST_RUN;
            ST_DONE: begin
                if (ctl_off)     state_d = ST_OFF;
                else if (val_we) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign expire = (state_q == ST_RUN) && (state_d == ST_DONE);
    assign decr   = (state_q == ST_RUN) && !ctl_off && !val_we && (count_q != '0);

    // datapath registers steered by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            ie_q      <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            if (val_we && en)  count_q <= wdata;
            else if (decr)     count_q <= count_q - 1'b1;
            if (ctrl_we)       ie_q <= w_en && w_ie;
            if (expire)                 pending_q <= 1'b1;
            else if (ctl_on && w_clr)   pending_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        en     = (state_q == ST_IDLE) || (state_q == ST_RUN) || (state_q == ST_DONE);
        irq_en = ie_q;
        count  = count_q;
        irq    = pending_q && ie_q;
    end

    AST_LOAD_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && !en) |=> $stable(count_q)); // R3
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && en) |=> (count_q == $past(wdata))); // R3
    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && count_q <= DATA_W'(1) && !ctrl_we && !val_we) |=> (pending_q && count_q == '0)); // R4
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (count_q == '0)); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en); // R6
    AST_OFF_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_off |=> $stable(pending_q)); // R6
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ctl_on) |=> $stable(count_q)); // R7
endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic              ctrl_we, val_we, en, irq_en;
    logic [DATA_W-1:0] count;

    tmr_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
    ) u_regif (
        .wr_en(wr_en), .addr(addr), .en(en), .irq_en(irq_en), .count(count),
        .ctrl_we(ctrl_we), .val_we(val_we), .rdata(rdata)
    );

    tmr_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .val_we(val_we),
        .wdata(wdata), .en(en), .irq_en(irq_en), .count(count), .irq(irq)
    );
endmodule

// File: tb/evt_countdown_timer_test.sv
module evt_countdown_timer_test;
    localparam logic [7:0] A_CTL = 8'h40;
    localparam logic [7:0] A_VAL = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; consumes exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_CTL, v); chk("R1 ctrl", v, 0);
        peek(A_VAL, v); chk("R1 value", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R3 value write ignored while disabled
        wr(A_VAL, 32'd5);
        peek(A_VAL, v); chk("R3 ignored when off", v, 0);

        // R2 aliases and unmapped offsets
        wr(8'hC0, 32'h3);
        peek(A_CTL, v); chk("R2 alias 0xC0", v, 0);
        wr(8'h48, 32'h3);
        peek(A_CTL, v); chk("R2 write 0x48", v, 0);
        peek(8'h48, v); chk("R2 read 0x48", v, 0);

        // R4/R5 sweep of start values
        for (int sv = 0; sv <= 12; sv++) begin
            int steps;
            steps = (sv == 0) ? 1 : sv;
            wr(A_CTL, 32'h13);
            wr(A_VAL, sv);
            peek(A_VAL, v); chk("R3 load", v, sv);
            chk("R5 irq before expiry", {31'b0, irq}, 0);
            for (int k = 1; k <= steps; k++) begin
                tick(1);
                peek(A_VAL, v);
                chk("R4 count", v, (sv > k) ? sv - k : 0);
                chk("R4 R5 irq timing", {31'b0, irq}, (k >= steps) ? 1 : 0);
            end
            tick(2);
            peek(A_VAL, v); chk("R4 stays at zero", v, 0);
        end

        // R6/R8/R5 sweep of control patterns with an event pending
        for (int c = 0; c < 32; c++) begin
            logic xen, xie, xpend;
            wr(A_CTL, 32'h01);
            wr(A_VAL, 32'd0);
            tick(1);
            wr(A_CTL, c);
            xen = c[0];
            xie = c[0] & c[1];
            xpend = !(c[0] & c[4]);
            peek(A_CTL, v); chk("R6 R8 ctrl readback", v, {30'b0, xie, xen});
            chk("R5 irq gating", {31'b0, irq}, {31'b0, xie & xpend});
            wr(A_CTL, 32'h03);
            chk("R6 pending kept or cleared", {31'b0, irq}, {31'b0, xpend});
        end

        // R7 freeze and resume
        wr(A_CTL, 32'h13);
        wr(A_VAL, 32'd10);
        tick(3);
        wr(A_CTL, 32'h00);
        peek(A_VAL, v); chk("R7 frozen at disable", v, 7);
        tick(5);
        peek(A_VAL, v); chk("R7 frozen while off", v, 7);
        wr(A_VAL, 32'd99);
        peek(A_VAL, v); chk("R7 value write in hold", v, 7);
        wr(A_CTL, 32'h03);
        peek(A_VAL, v); chk("R7 resume edge", v, 7);
        tick(6);
        peek(A_VAL, v); chk("R7 resumed count", v, 1);
        chk("R7 no irq yet", {31'b0, irq}, 0);
        tick(1);
        chk("R7 irq after resume", {31'b0, irq}, 1);

        // R9 reload during a countdown
        wr(A_CTL, 32'h13);
        wr(A_VAL, 32'd10);
        tick(2);
        wr(A_VAL, 32'd5);
        peek(A_VAL, v); chk("R9 reload", v, 5);
        tick(4);
        chk("R9 no irq early", {31'b0, irq}, 0);
        tick(1);
        chk("R9 irq on reload expiry", {31'b0, irq}, 1);

        // R10 clear on the expiry edge
        wr(A_CTL, 32'h13);
        wr(A_VAL, 32'd4);
        tick(3);
        wr(A_CTL, 32'h13);
        chk("R10 expiry beats clear", {31'b0, irq}, 1);
        wr(A_CTL, 32'h13);
        chk("R10 later clear", {31'b0, irq}, 0);

        // R3 full-scale value
        wr(A_VAL, 32'hFFFF_FFFF);
        tick(3);
        peek(A_VAL, v); chk("R3 full scale", v, 32'hFFFF_FFFC);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R1-all act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule